// File: doc/BRIEF.md
# Current-Limited Fixed-Frequency PWM Generator

This block drives the high-side switch enable of a step-down converter. The period is fixed and set by the ratio of the system clock to the 500 kHz switching rate. Each period starts with a gate pulse whose length in clock cycles comes from a command word. That length is clamped to 80% of the period, and a command of zero gives no pulse.

An overcurrent comparator input can cut the pulse short. It is ignored during a leading-edge blanking window of about 100 ns. Once it trips, the gate stays off until the next period begins, and a one-clock event pulse tells an external fault sequencer that this period hit the limit. A period-start strobe lets the same sequencer count consecutive limited periods. An enable input and a fault-shutdown input both force the switch off without delay, and they restart the period counter.

Top module: `pwm_cl_top`

## Requirements
- R1: With default parameters a switching period is 250 clock cycles. `cycle_start_o` is high for exactly the first cycle of each period, so two consecutive strobes are 250 cycles apart.
- R2: `duty_i` is an on-time in clock cycles. Without overcurrent, `gate_o` is high in period positions 0 to N-1 and low for the rest of the period, where N = min(`duty_i`, 200).
- R3: The on-time never exceeds 200 cycles (80% of the period). A command of 255 gives exactly 200 high cycles.
- R4: A command of 0 keeps `gate_o` low for the whole period.
- R5: A command change in the middle of a period leaves that period's pulse unchanged. The new value applies from the next period.
- R6: `oc_i` has no effect in period positions 0 to 12 (the blanking window of 13 cycles). Blanking never makes a pulse longer than its command.
- R7: When `oc_i` is high at a position of 13 or later inside the on-time, `gate_o` is low in that same cycle. It stays low until the period ends, even if `oc_i` falls again.
- R8: `oc_i` outside the on-time does not change `gate_o` and raises no event.
- R9: `oc_event_o` is a one-cycle pulse in the cycle after the trip. It occurs at most once per period.
- R10: While `en_i` is low or `fault_i` is high, `gate_o` and `cycle_start_o` are low in the same cycle. When both are released, a new period begins at once at position 0.
- R11: During reset, and with `en_i` low, `gate_o`, `oc_event_o` and `cycle_start_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (125 MHz by default) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Regulator enable |
| fault_i | input | 1 | Shutdown request from the fault sequencer |
| duty_i | input | 8 | On-time command in clock cycles |
| oc_i | input | 1 | Overcurrent comparator output |
| gate_o | output | 1 | High-side switch enable |
| cycle_start_o | output | 1 | Strobe on the first cycle of each period |
| oc_event_o | output | 1 | Strobe after a current-limit trip |

## Verification
On every cycle, the assertions check the duty cap, the forced-off state under disable or fault, and that the gate is on during blanking whenever the command covers that position. They also check that the latched command is stable within a period, that period strobes occur only at wrap or restart, and that an event is a single pulse with the gate already off. Only the directed scenarios can show the exact pulse lengths for a given command, the blanking boundary, and that the trip latch holds after `oc_i` falls and clears at the next period. The same applies to ignoring `oc_i` during off-time and to the immediate restart after a fault is released.

// File: rtl/pwm_cl_pkg.sv
package pwm_cl_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/pwm_cl_period.sv
module pwm_cl_period #(
  parameter int PERIOD = 250,
  parameter int CNT_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign last_o  = run_i && (cnt_q == LAST_C);
  assign start_o = run_i && (cnt_q == '0);

  p_start_at_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (($past(cnt_q) == LAST_C) || !$past(run_i)));
endmodule

// File: rtl/pwm_cl_cmd.sv
module pwm_cl_cmd #(
  parameter int CNT_W  = 8,
  parameter int MAX_ON = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] on_len_o
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ON);

  logic [CNT_W-1:0] clamped;
  logic [CNT_W-1:0] on_len_q;

  assign clamped = (duty_i > MAX_C) ? MAX_C : duty_i;

  // reload only at a period boundary or while idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               on_len_q <= '0;
    else if (!run_i || last_i) on_len_q <= clamped;
  end

  assign on_len_o = on_len_q;

  p_cmd_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && cnt_i != '0) |-> $stable(on_len_q));
endmodule

// File: rtl/pwm_cl_limit.sv
module pwm_cl_limit #(
  parameter int CNT_W = 8,
  parameter int BLANK = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             last_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] on_len_i,
  input  logic             oc_i,
  output logic             gate_o,
  output logic             oc_event_o
);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  logic on_win, past_blank, oc_hit, trip_now;
  logic trip_q, evt_q;

  assign on_win     = cnt_i < on_len_i;
  assign past_blank = cnt_i >= BLANK_C;
  assign oc_hit     = oc_i && past_blank;
  assign trip_now   = run_i && on_win && oc_hit && !trip_q;
  assign gate_o     = run_i && on_win && !trip_q && !oc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= trip_now;
      if (!run_i || last_i) trip_q <= 1'b0;
      else if (trip_now)    trip_q <= 1'b1;
    end
  end

  assign oc_event_o = evt_q;

  p_blank_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i < BLANK_C && cnt_i < on_len_i) |-> gate_o);
endmodule

// File: rtl/pwm_cl_top.sv
module pwm_cl_top #(
  parameter int CLK_HZ       = 125_000_000,
  parameter int SW_HZ        = 500_000,
  parameter int MAX_DUTY_PCT = 80,
  parameter int BLANK_NS     = 100,
  parameter int PERIOD       = CLK_HZ / SW_HZ,
  parameter int CNT_W        = $clog2(PERIOD)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             oc_i,
  output logic             gate_o,
  output logic             cycle_start_o,
  output logic             oc_event_o
);
  import pwm_cl_pkg::*;

  localparam int MAX_ON = (PERIOD * MAX_DUTY_PCT) / 100;
  localparam int BLANK  = ceil_div(BLANK_NS * (CLK_HZ / 1_000_000), 1000);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_ON);

  logic             rdy_q, run, last;
  logic [CNT_W-1:0] cnt, on_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= 1'b1;
  end

  assign run = rdy_q && en_i && !fault_i;

  pwm_cl_period #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_period (
    .clk_i, .rst_ni, .run_i(run), .cnt_o(cnt), .last_o(last), .start_o(cycle_start_o)
  );

  pwm_cl_cmd #(.CNT_W(CNT_W), .MAX_ON(MAX_ON)) u_cmd (
    .clk_i, .rst_ni, .run_i(run), .last_i(last), .cnt_i(cnt), .duty_i, .on_len_o(on_len)
  );

  pwm_cl_limit #(.CNT_W(CNT_W), .BLANK(BLANK)) u_limit (
    .clk_i, .rst_ni, .run_i(run), .last_i(last), .cnt_i(cnt), .on_len_i(on_len),
    .oc_i, .gate_o, .oc_event_o
  );

  p_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> (cnt < MAX_C));
  p_forced_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || fault_i) |-> (!gate_o && !cycle_start_o));
  p_event_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_event_o |=> !oc_event_o);
  p_event_gate_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oc_event_o |-> !gate_o);
endmodule

// File: tb/pwm_cl_top_bench.sv
module pwm_cl_top_bench;
  localparam int P = 250;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       en = 1'b0, fault = 1'b0, oc = 1'b0;
  logic [7:0] duty = '0;
  logic       gate, cstart, oc_evt;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  pwm_cl_top u_pwm_cl_top (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault), .duty_i(duty),
    .oc_i(oc), .gate_o(gate), .cycle_start_o(cstart), .oc_event_o(oc_evt)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    @(negedge clk); #1;
    while (!cstart) begin @(negedge clk); #1; end
  endtask

  // one full period; oc high for positions [oc_from, oc_to)
  task automatic run_period(input int oc_from, input int oc_to, input int chg_at,
                            input int chg_val, output int on_cnt, output int ev_cnt,
                            output int ev_pos);
    on_cnt = 0; ev_cnt = 0; ev_pos = -1;
    wait_start();
    for (int k = 0; k < P; k++) begin
      if (k > 0) begin @(negedge clk); #1; end
      oc = (k >= oc_from) && (k < oc_to);
      if (k == chg_at) duty = 8'(chg_val);
      #1;
      if (gate) on_cnt++;
      if (oc_evt) begin ev_cnt++; ev_pos = k; end
    end
    oc = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 gate in reset", gate, 0);
    check("R11 event in reset", oc_evt, 0);
    check("R11 start in reset", cstart, 0);
  endtask

  task automatic t_period_len();
    int n = 0;
    wait_start();
    do begin @(negedge clk); #1; n++; end while (!cstart);
    check("R1 period length", n, P);
  endtask

  task automatic t_duty(input int d, input int exp, input string req);
    int c, e, p;
    duty = 8'(d);
    run_period(-1, -1, -1, 0, c, e, p);
    run_period(-1, -1, -1, 0, c, e, p);
    check(req, c, exp);
    check({req, " no event"}, e, 0);
  endtask

  task automatic t_midchange();
    int c, e, p;
    duty = 8'd100;
    run_period(-1, -1, -1, 0, c, e, p);
    run_period(-1, -1, 20, 40, c, e, p);
    check("R5 old width kept", c, 100);
    run_period(-1, -1, -1, 0, c, e, p);
    check("R5 new width applied", c, 40);
  endtask

  task automatic t_oc(input int d, input int from, input int to, input int exp_on,
                      input int exp_ev, input int exp_pos, input string req);
    int c, e, p;
    duty = 8'(d);
    run_period(-1, -1, -1, 0, c, e, p);
    run_period(from, to, -1, 0, c, e, p);
    check({req, " on cycles"}, c, exp_on);
    check({req, " event count R9"}, e, exp_ev);
    if (exp_ev > 0) check({req, " event position R9"}, p, exp_pos);
  endtask

  task automatic t_recover();
    int c, e, p;
    run_period(-1, -1, -1, 0, c, e, p);
    check("R7 latch cleared next period", c, 100);
  endtask

  task automatic t_fault();
    duty = 8'd100;
    wait_start();
    repeat (50) @(negedge clk);
    #1; check("R10 gate high before fault", gate, 1);
    fault = 1'b1; #1;
    check("R10 fault forces gate off", gate, 0);
    repeat (10) @(negedge clk);
    #1; check("R10 no start under fault", cstart, 0);
    fault = 1'b0; #1;
    check("R10 restart strobe", cstart, 1);
    check("R10 restart gate on", gate, 1);
    repeat (30) @(negedge clk);
    #1; en = 1'b0; #1;
    check("R10 disable forces gate off", gate, 0);
    check("R11 no start while disabled", cstart, 0);
    @(negedge clk); #1; en = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1; t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1; t_reset();
    duty = 8'd100;
    en = 1'b1;
    t_period_len();
    t_duty(100, 100, "R2 width 100");
    t_duty(7, 7, "R2 width 7");
    t_duty(255, 200, "R3 clamp 255");
    t_duty(200, 200, "R3 at cap");
    t_duty(0, 0, "R4 zero");
    t_midchange();
    t_oc(100, 0, P, 13, 1, 14, "R6 oc from start");
    t_recover();
    t_oc(5, 0, P, 5, 0, 0, "R6 short pulse not lengthened");
    t_oc(100, 5, 12, 100, 0, 0, "R6 oc only in blank");
    t_oc(100, 40, 45, 40, 1, 41, "R7 trip stays off");
    t_oc(100, 20, 120, 20, 1, 21, "R7 trip at 20");
    t_oc(100, 150, P, 100, 0, 0, "R8 oc in off time");
    t_fault();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule